// File: doc/BRIEF.md
# Drift-Chamber Pulse Hit Finder

This block watches the digitized sample stream of one drift-chamber channel and turns each trigger into a single hit record. While no trigger is pending it keeps a running pedestal: the mean of the most recent samples, formed with a shift rather than a divider. Once a trigger arrives the pedestal is frozen, so the tail of an earlier pulse that is still present at trigger time cannot bias it. The block then searches the trigger window for the first sample whose pedestal-subtracted value rises above a programmable threshold.

A crossing only counts as a hit if the step from the previous sample is at least a programmable minimum slope. A value near 30 counts per sample separates real leading edges from slowly drifting noise. The signal must also stay above threshold for a minimum pulse width. For an accepted hit the block reports four things: the crossing time, refined to 1/64 sample by a short serial divide; the height of the first local maximum; a quality flag; and an integral. The integral runs from the crossing sample to a fixed sample count after the trigger. If the window closes without an accepted hit, a record with the valid flag low is issued instead.

Window samples are numbered from 1, starting with the first valid sample after the trigger cycle. The sample accepted on the trigger cycle is the reference for index 1 but is not part of the window. `cfgWindow` must be at least 1.

Top module: `pulse_hit_finder`

## Requirements
- R1: After reset, `hitStrobe` and `hitValid` are low, and no record appears until a trigger window completes.
- R2: The pedestal is the floor of the mean of the last 4 valid samples accepted while idle with `trigger` low. It stays unchanged from the trigger until the record is issued.
- R3: A sample is over threshold when (sample − pedestal) > `cfgThreshold`, so a value equal to the threshold is not over. A crossing is a window sample that is over threshold while its predecessor is not.
- R4: A crossing is a candidate only if (current − previous) ≥ `cfgMinSlope`, with both values pedestal-subtracted. Otherwise it is ignored and the search goes on.
- R5: A candidate is accepted once it has been over threshold for 5 consecutive window samples, counting the crossing sample. If it falls to or below threshold earlier, it is dropped and the search resumes.
- R6: `hitTime` = (c−1)·64 + floor(64·(thr − prev)/(cur − prev)), where c is the crossing index and prev and cur are the pedestal-subtracted values around it. The upper 10 bits hold the integer part and the low 6 bits the fraction.
- R7: `hitIntegral` is the signed sum of the pedestal-subtracted samples from the crossing index through index `cfgWindow`, inclusive.
- R8: `hitPeak` is the last value of the run of strictly increasing samples that starts at the crossing. `hitQuality` is 1 if that run ended inside the window. If the signal was still rising at the window end, `hitQuality` is 0 and `hitPeak` is the last sample.
- R9: Only the first accepted candidate after a trigger is reported. A trigger that arrives while a window or report is in progress has no effect.
- R10: `hitStrobe` is a one-cycle pulse, high 8 cycles after the clock edge that captures window sample `cfgWindow`. With no accepted hit, `hitValid` is 0 and the time, integral, peak and quality outputs are 0.
- R11: Cycles with `sampleValid` low advance neither the pedestal nor the window, and do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle at most |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | `sampleIn` holds a sample this cycle |
| sampleIn | input | 12 | Raw unsigned ADC sample |
| trigger | input | 1 | Opens a window when the block is idle |
| cfgThreshold | input | 12 | Threshold above the pedestal |
| cfgMinSlope | input | 12 | Minimum leading-edge step per sample |
| cfgWindow | input | 10 | Window length in samples after the trigger |
| hitStrobe | output | 1 | One-cycle record strobe |
| hitValid | output | 1 | Record holds an accepted hit |
| hitTime | output | 16 | Crossing time, 10.6 fixed point in samples |
| hitIntegral | output | 23 | Signed integral from the crossing to the window end |
| hitPeak | output | 12 | First local maximum above the pedestal |
| hitQuality | output | 1 | Rise of the pulse ended within the window |

## Verification
The record depends on exactly one timing point: the edge that captures the last window sample into the input register. One edge later the window closes, six edges run the fractional divide, and one more edge loads the outputs, so the strobe is due 8 edges after that capture. Each scenario ends by stepping exactly that many edges. The bench checks the strobe low one edge early, high on the due edge, and low again one edge later, and compares every record field only in the strobe cycle. Gapped-valid runs keep that count tied to the last valid sample, not to the number of clock cycles in the window.

// File: rtl/phf_pkg.sv
package phf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARMED,
    PH_DIVIDE,
    PH_REPORT
  } phase_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic pedShift;
    logic winClear;
    logic winStep;
    logic candStart;
    logic candAccum;
    logic divIter;
    logic emitHit;
    logic emitNone;
  } ctrl_t;

  // conditions from the datapath back to control
  typedef struct packed {
    logic smpValid;
    logic trigSeen;
    logic over;
    logic crossOk;
    logic lastSmp;
  } stat_t;

endpackage

// File: rtl/phf_datapath.sv
module phf_datapath
  import phf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_W    = 10,
  parameter int FRAC_W   = 6,
  parameter int PED_TAPS = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              smpValid,
  input  logic [SAMPLE_W-1:0]               smpIn,
  input  logic                              trigIn,
  input  logic [SAMPLE_W-1:0]               cfgThreshold,
  input  logic [SAMPLE_W-1:0]               cfgMinSlope,
  input  logic [WIN_W-1:0]                  cfgWindow,
  input  ctrl_t                             ctrl,
  output stat_t                             stat,
  output logic [SAMPLE_W-1:0]               pedValue,
  output logic                              hitStrobe,
  output logic                              hitValid,
  output logic [WIN_W+FRAC_W-1:0]           hitTime,
  output logic signed [SAMPLE_W+WIN_W:0]    hitIntegral,
  output logic [SAMPLE_W-1:0]               hitPeak,
  output logic                              hitQuality
);
  localparam int SUB_W  = SAMPLE_W + 1;
  localparam int STEP_W = SAMPLE_W + 2;
  localparam int ACC_W  = SUB_W + WIN_W;
  localparam int PED_SH = $clog2(PED_TAPS);
  localparam int PSUM_W = SAMPLE_W + PED_SH;
  localparam logic [WIN_W:0] IDX_ONE = 1;

  logic [SAMPLE_W-1:0]      smpR;
  logic                     vldR, trigR;
  logic [SAMPLE_W-1:0]      pedTap [PED_TAPS-1];
  logic [SAMPLE_W-1:0]      pedR;
  logic [PSUM_W-1:0]        pedSumNext;
  logic signed [SUB_W-1:0]  curSub, prevSub, thrS, peakR;
  logic signed [STEP_W-1:0] curX, prevX, thrX, stepS, numS, slopeMin;
  logic [WIN_W-1:0]         winIdx, timeInt;
  logic signed [ACC_W-1:0]  accR;
  logic                     peakDone;
  logic [STEP_W-1:0]        remR, denR;
  logic [STEP_W:0]          remTwo, remDiff;
  logic                     remGe;
  logic [FRAC_W-1:0]        quoR;

  always_comb begin
    pedSumNext = PSUM_W'(smpR);
    for (int i = 0; i < PED_TAPS - 1; i++) pedSumNext = pedSumNext + PSUM_W'(pedTap[i]);
  end

  assign curSub   = $signed({1'b0, smpR}) - $signed({1'b0, pedR});
  assign thrS     = $signed({1'b0, cfgThreshold});
  assign curX     = {curSub[SUB_W-1], curSub};
  assign prevX    = {prevSub[SUB_W-1], prevSub};
  assign thrX     = $signed({2'b00, cfgThreshold});
  assign slopeMin = $signed({2'b00, cfgMinSlope});
  assign stepS    = curX - prevX;
  assign numS     = thrX - prevX;
  assign remTwo   = {remR, 1'b0};
  assign remDiff  = remTwo - {1'b0, denR};
  assign remGe    = remTwo >= {1'b0, denR};
  assign pedValue = pedR;

  assign stat.smpValid = vldR;
  assign stat.trigSeen = trigR;
  assign stat.over     = curSub > thrS;
  assign stat.crossOk  = (curSub > thrS) && !(prevSub > thrS) && (stepS >= slopeMin);
  assign stat.lastSmp  = ({1'b0, winIdx} + IDX_ONE) >= {1'b0, cfgWindow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpR <= '0; vldR <= 1'b0; trigR <= 1'b0;
      for (int i = 0; i < PED_TAPS - 1; i++) pedTap[i] <= '0;
      pedR <= '0; prevSub <= '0; winIdx <= '0; timeInt <= '0;
      accR <= '0; peakR <= '0; peakDone <= 1'b0;
      remR <= '0; denR <= '0; quoR <= '0;
      hitStrobe <= 1'b0; hitValid <= 1'b0; hitTime <= '0;
      hitIntegral <= '0; hitPeak <= '0; hitQuality <= 1'b0;
    end else begin
      smpR  <= smpIn;
      vldR  <= smpValid;
      trigR <= trigIn;
      if (vldR) prevSub <= curSub;
      if (ctrl.pedShift) begin
        pedTap[0] <= smpR;
        for (int i = 1; i < PED_TAPS - 1; i++) pedTap[i] <= pedTap[i-1];
        pedR <= pedSumNext[PSUM_W-1:PED_SH];
      end
      if (ctrl.winClear) winIdx <= '0;
      else if (ctrl.winStep) winIdx <= winIdx + WIN_W'(1);
      if (ctrl.candStart) begin
        accR     <= {{WIN_W{curSub[SUB_W-1]}}, curSub};
        peakR    <= curSub;
        peakDone <= 1'b0;
        timeInt  <= winIdx;
        remR     <= numS;
        denR     <= stepS;
        quoR     <= '0;
      end else if (ctrl.candAccum) begin
        accR <= accR + {{WIN_W{curSub[SUB_W-1]}}, curSub};
        if (!peakDone) begin
          if (curSub > peakR) peakR <= curSub;
          else peakDone <= 1'b1;
        end
      end
      if (ctrl.divIter) begin
        remR <= remGe ? remDiff[STEP_W-1:0] : remTwo[STEP_W-1:0];
        quoR <= {quoR[FRAC_W-2:0], remGe};
      end
      hitStrobe <= ctrl.emitHit | ctrl.emitNone;
      if (ctrl.emitHit | ctrl.emitNone) begin
        hitValid    <= ctrl.emitHit;
        hitTime     <= ctrl.emitHit ? {timeInt, quoR} : '0;
        hitIntegral <= ctrl.emitHit ? accR : '0;
        hitPeak     <= ctrl.emitHit ? peakR[SAMPLE_W-1:0] : '0;
        hitQuality  <= ctrl.emitHit & peakDone;
      end
    end
  end

endmodule

// File: rtl/phf_control.sv
module phf_control
  import phf_pkg::*;
#(
  parameter int FRAC_W    = 6,
  parameter int MIN_WIDTH = 5
) (
  input  logic  clk,
  input  logic  rstN,
  input  stat_t stat,
  output ctrl_t ctrl
);
  localparam int CNT_W = $clog2(MIN_WIDTH + 1);
  localparam int DIV_W = $clog2(FRAC_W);

  phase_e           phase, phaseN;
  logic             cand, candN, locked, lockedN;
  logic [CNT_W-1:0] widthCnt, widthN, widthInc;
  logic [DIV_W-1:0] divCnt, divN;

  assign widthInc = widthCnt + CNT_W'(1);

  always_comb begin
    ctrl    = '0;
    phaseN  = phase;
    candN   = cand;
    lockedN = locked;
    widthN  = widthCnt;
    divN    = divCnt;
    case (phase)
      PH_IDLE: begin
        ctrl.pedShift = stat.smpValid & ~stat.trigSeen;
        if (stat.trigSeen) begin
          ctrl.winClear = 1'b1;
          phaseN  = PH_ARMED;
          candN   = 1'b0;
          lockedN = 1'b0;
          widthN  = '0;
        end
      end
      PH_ARMED: begin
        if (stat.smpValid) begin
          ctrl.winStep = 1'b1;
          if (locked) begin
            ctrl.candAccum = 1'b1;
          end else if (cand) begin
            if (stat.over) begin
              ctrl.candAccum = 1'b1;
              widthN = widthInc;
              if (widthInc == CNT_W'(MIN_WIDTH)) begin
                lockedN = 1'b1;
                candN   = 1'b0;
              end
            end else begin
              candN = 1'b0;
            end
          end else if (stat.crossOk) begin
            ctrl.candStart = 1'b1;
            widthN = CNT_W'(1);
            if (MIN_WIDTH <= 1) lockedN = 1'b1;
            else candN = 1'b1;
          end
          if (stat.lastSmp) begin
            phaseN = PH_DIVIDE;
            divN   = '0;
          end
        end
      end
      PH_DIVIDE: begin
        ctrl.divIter = 1'b1;
        divN = divCnt + DIV_W'(1);
        if (divCnt == DIV_W'(FRAC_W - 1)) phaseN = PH_REPORT;
      end
      default: begin
        ctrl.emitHit  = locked;
        ctrl.emitNone = ~locked;
        phaseN = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cand     <= 1'b0;
      locked   <= 1'b0;
      widthCnt <= '0;
      divCnt   <= '0;
    end else begin
      phase    <= phaseN;
      cand     <= candN;
      locked   <= lockedN;
      widthCnt <= widthN;
      divCnt   <= divN;
    end
  end

endmodule

// File: rtl/pulse_hit_finder.sv
module pulse_hit_finder
  import phf_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int WIN_W     = 10,
  parameter int FRAC_W    = 6,
  parameter int PED_TAPS  = 4,
  parameter int MIN_WIDTH = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sampleValid,
  input  logic [SAMPLE_W-1:0]            sampleIn,
  input  logic                           trigger,
  input  logic [SAMPLE_W-1:0]            cfgThreshold,
  input  logic [SAMPLE_W-1:0]            cfgMinSlope,
  input  logic [WIN_W-1:0]               cfgWindow,
  output logic                           hitStrobe,
  output logic                           hitValid,
  output logic [WIN_W+FRAC_W-1:0]        hitTime,
  output logic signed [SAMPLE_W+WIN_W:0] hitIntegral,
  output logic [SAMPLE_W-1:0]            hitPeak,
  output logic                           hitQuality
);
  ctrl_t               ctrlBus;
  stat_t               statBus;
  logic [SAMPLE_W-1:0] pedValue;

  phf_control #(.FRAC_W(FRAC_W), .MIN_WIDTH(MIN_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(statBus), .ctrl(ctrlBus)
  );

  phf_datapath #(.SAMPLE_W(SAMPLE_W), .WIN_W(WIN_W), .FRAC_W(FRAC_W), .PED_TAPS(PED_TAPS)) u_dp (
    .clk(clk), .rstN(rstN),
    .smpValid(sampleValid), .smpIn(sampleIn), .trigIn(trigger),
    .cfgThreshold(cfgThreshold), .cfgMinSlope(cfgMinSlope), .cfgWindow(cfgWindow),
    .ctrl(ctrlBus), .stat(statBus), .pedValue(pedValue),
    .hitStrobe(hitStrobe), .hitValid(hitValid), .hitTime(hitTime),
    .hitIntegral(hitIntegral), .hitPeak(hitPeak), .hitQuality(hitQuality)
  );

endmodule

// File: rtl/phf_checker.sv
module phf_checker
  import phf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_W    = 10,
  parameter int FRAC_W   = 6
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           hitStrobe,
  input logic                           hitValid,
  input logic [WIN_W+FRAC_W-1:0]        hitTime,
  input logic signed [SAMPLE_W+WIN_W:0] hitIntegral,
  input logic [SAMPLE_W-1:0]            hitPeak,
  input logic                           hitQuality,
  input logic [SAMPLE_W-1:0]            cfgThreshold,
  input ctrl_t                          ctrlBus,
  input logic [SAMPLE_W-1:0]            pedValue
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hitStrobe |=> !hitStrobe); // R10

  AST_NOHIT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (hitStrobe && !hitValid) |-> (hitTime == '0 && hitIntegral == '0 && hitPeak == '0 && !hitQuality)); // R10

  AST_VALID_RISES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitValid) |-> hitStrobe); // R10

  AST_PEAK_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hitStrobe && hitValid) |-> (hitPeak > cfgThreshold)); // R8

  AST_QUALITY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hitQuality |-> hitValid); // R8

  AST_PEDESTAL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlBus.pedShift) |-> $stable(pedValue)); // R2

endmodule

bind pulse_hit_finder phf_checker #(.SAMPLE_W(SAMPLE_W), .WIN_W(WIN_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .hitStrobe(hitStrobe), .hitValid(hitValid),
  .hitTime(hitTime), .hitIntegral(hitIntegral), .hitPeak(hitPeak),
  .hitQuality(hitQuality), .cfgThreshold(cfgThreshold),
  .ctrlBus(ctrlBus), .pedValue(pedValue)
);

// File: tb/pulse_hit_finder_tb_top.sv
module pulse_hit_finder_tb_top;

  typedef struct packed {
    int base; int thr; int slope; int win;
    int p; int r; int top; int len; int p2;
  } vec_t;

  // base, thr, slope, win, pulse start, rise step, top, length, 2nd pulse start
  localparam vec_t VEC [10] = '{
    '{100,  50, 30, 20,  5,  40,  200,  8,  0},  // clean hit
    '{100,  50, 30, 25,  5,  10,  200, 15,  0},  // slow rise, R4 reject
    '{100,  50, 30, 20,  5,  60,  300,  3,  0},  // too short, R5 reject
    '{100,  50, 30, 10, 15,  40,  200,  8,  0},  // pulse after window
    '{100,  50, 30, 12,  5,  35,  500, 30,  0},  // still rising at end
    '{200, 100, 40, 30,  3, 300, 1000, 10, 18},  // two pulses, R9
    '{100,  50, 30, 16, 12,  80,  400, 10,  0},  // width done on last sample
    '{100,  50, 60, 15,  4,  60,  300,  8,  0},  // step equals min slope
    '{100,  50, 61, 15,  4,  60,  300,  8,  0},  // step one below min slope
    '{100,  48, 30, 20,  4,  50,  300,  8,  0}   // sample equal to threshold
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        trigger = 1'b0;
  logic [11:0] cfgThreshold = '0;
  logic [11:0] cfgMinSlope = 12'd30;
  logic [9:0]  cfgWindow = 10'd1;
  logic        hitStrobe, hitValid, hitQuality;
  logic [15:0] hitTime;
  logic signed [22:0] hitIntegral;
  logic [11:0] hitPeak;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pulse_hit_finder dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .trigger(trigger), .cfgThreshold(cfgThreshold), .cfgMinSlope(cfgMinSlope),
    .cfgWindow(cfgWindow), .hitStrobe(hitStrobe), .hitValid(hitValid),
    .hitTime(hitTime), .hitIntegral(hitIntegral), .hitPeak(hitPeak),
    .hitQuality(hitQuality)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic int amp(input int j, input int r, input int top, input int len);
    int a;
    if (j < 0 || j >= len) return 0;
    a = r * (j + 1);
    return (a > top) ? top : a;
  endfunction

  function automatic int smpAt(input vec_t v, input int i);
    int s;
    s = v.base + amp(i - v.p, v.r, v.top, v.len);
    if (v.p2 > 0) s = s + amp(i - v.p2, v.r, v.top, v.len);
    return (s > 4095) ? 4095 : s;
  endfunction

  // reference results written from R2..R9
  task automatic expect_rec(input vec_t v, output int eV, output int eT,
                            output int eI, output int eP, output int eQ);
    int ped, prev, cur, wcnt, acc, pk, tm;
    bit cand, locked, pdone;
    ped = (4 * v.base + 0 + 1 + 2 + 5) / 4;  // R2
    prev = v.base - ped;
    cand = 0; locked = 0; pdone = 0; wcnt = 0; acc = 0; pk = 0; tm = 0;
    for (int i = 1; i <= v.win; i++) begin
      cur = smpAt(v, i) - ped;
      if (locked || (cand && cur > v.thr)) begin
        acc += cur;
        if (!pdone) begin
          if (cur > pk) pk = cur; else pdone = 1;
        end
        if (cand) begin
          wcnt++;
          if (wcnt == 5) begin locked = 1; cand = 0; end
        end
      end else if (cand) begin
        cand = 0;
      end else if (cur > v.thr && prev <= v.thr && (cur - prev) >= v.slope) begin
        cand = 1; wcnt = 1; acc = cur; pk = cur; pdone = 0;
        tm = (i - 1) * 64 + (64 * (v.thr - prev)) / (cur - prev);
      end
      prev = cur;
    end
    eV = locked;
    eT = locked ? tm : 0;
    eI = locked ? acc : 0;
    eP = locked ? pk : 0;
    eQ = locked ? int'(pdone) : 0;
  endtask

  task automatic drive(input int s, input bit trg, input bit vld);
    @(negedge clk);
    sampleIn = 12'(s);
    trigger = trg;
    sampleValid = vld;
  endtask

  task automatic run_vec(input vec_t v, input bit gaps, input string tag);
    int eV, eT, eI, eP, eQ;
    @(negedge clk);
    cfgThreshold = 12'(v.thr);
    cfgMinSlope = 12'(v.slope);
    cfgWindow = 10'(v.win);
    for (int k = 0; k < 4; k++) drive(3000, 0, 1);  // flushed out of the pedestal
    drive(v.base + 0, 0, 1);
    drive(v.base + 1, 0, 1);
    drive(v.base + 2, 0, 1);
    drive(v.base + 5, 0, 1);
    drive(v.base, 1, 1);
    for (int i = 1; i <= v.win; i++) begin
      if (gaps) drive(4000, 1, 0);            // R11: invalid cycle, also a trigger
      drive(smpAt(v, i), (i == 3), 1);        // R9: retrigger inside the window
    end
    @(posedge clk);                           // last window sample captured
    @(negedge clk);
    sampleValid = 1'b0;
    trigger = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk({"R10 strobe early ", tag}, int'(hitStrobe), 0);
    @(posedge clk);
    @(negedge clk);
    expect_rec(v, eV, eT, eI, eP, eQ);
    chk({"R10 strobe due ", tag}, int'(hitStrobe), 1);
    chk({"R3/R4/R5 valid ", tag}, int'(hitValid), eV);
    chk({"R6/R2 time ", tag}, int'(hitTime), eT);
    chk({"R7/R9 integral ", tag}, int'(hitIntegral), eI);
    chk({"R8 peak ", tag}, int'(hitPeak), eP);
    chk({"R8 quality ", tag}, int'(hitQuality), eQ);
    @(posedge clk);
    @(negedge clk);
    chk({"R10 strobe single ", tag}, int'(hitStrobe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe in reset", int'(hitStrobe), 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe after reset", int'(hitStrobe), 0);
    chk("R1 valid after reset", int'(hitValid), 0);

    for (int n = 0; n < 10; n++) run_vec(VEC[n], 1'b0, $sformatf("vec%0d", n));

    // R11: gapped valid gives the same record
    run_vec(VEC[0], 1'b1, "gapped vec0");
    run_vec(VEC[5], 1'b1, "gapped vec5");

    // R1: a fresh reset clears a held record
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 valid cleared by reset", int'(hitValid), 0);
    rstN = 1'b1;
    run_vec(VEC[6], 1'b0, "after reset");

    finishRun();
  end

endmodule